// File: doc/BRIEF.md
# Type 1 Configuration Forwarding Decoder

This block sits in the address-decode path of a bus-to-bus bridge. For each address phase it receives, it looks at the captured address word, the bus command nibble, the crossing direction (downstream toward the secondary bus, or upstream toward the primary bus) and the bridge's primary, secondary and subordinate bus number registers. From these it decides whether the access should become a special cycle on the target bus, be passed on unchanged as a Type 1 access, be left to the bridge's other decoders, or be dropped. The decision, the command to drive on the target side and the address word are registered and presented one cycle later with a strobe.

In conventional (non-split) mode, a special cycle that is accepted is handled as a delayed request. The block holds a single entry for it. It asks the target side to launch the cycle and answers every initiator attempt with retry until the target side reports the master abort that ends a special cycle. The next matching attempt is then answered as complete and the entry is freed. When split mode is selected, the tracker stays idle and only the decision is reported.

Top module: `t1cfg_fwd_decoder`

## Requirements
- R1: An address phase is treated as Type 1 only when address bits [1:0] equal 01b. Any other value, or any command other than configuration read (1010b), configuration write (1011b) or special cycle (0001b), gives outcome OTHER (code 0).
- R2: Outcome SPECIAL (code 1) requires all of the following: command 1011b, bits [15:11] = 11111b, bits [10:8] = 111b, bits [7:2] = 000000b, and a matching bus number under R3. If any one of these fails, the access is not converted.
- R3: The bus number is taken from bits [23:16]. For a special-cycle match it is compared with the secondary bus register when upstream_i=0, and with the primary bus register when upstream_i=1.
- R4: On SPECIAL, cmd_o is 0001b. For every other outcome, cmd_o equals the received command. ad_o always equals the received address word.
- R5: Downstream, a Type 1 read or write whose bus number is greater than the secondary bus number and no greater than the subordinate bus number gives FORWARD (code 2). SPECIAL takes priority over FORWARD.
- R6: Upstream, a Type 1 configuration read always gives IGNORE (code 3). An upstream Type 1 write whose bus number lies outside [secondary, subordinate] gives FORWARD.
- R7: A received Type 1 special cycle command (0001b) gives IGNORE.
- R8: dec_valid_o pulses for exactly one cycle, in the cycle after valid_i is sampled high. No pulse appears without valid_i.
- R9: In conventional mode (split_mode_i=0) with the tracker idle, a SPECIAL decision pulses launch_o and returns resp_o = RETRY (01b) alongside the decision.
- R10: While the entry waits for abort_i, every SPECIAL attempt gets RETRY and launch_o stays low. After abort_i, the next attempt with the same address and direction gets COMPLETE (10b) and frees the entry. Any other attempt still gets RETRY.
- R11: When split_mode_i=1, launch_o stays low and resp_o stays NONE (00b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Address phase present |
| ad_i | input | 32 | Captured address word |
| cmd_i | input | 4 | Bus command |
| upstream_i | input | 1 | 1 = upstream crossing |
| split_mode_i | input | 1 | 1 = split-transaction mode, tracker off |
| pri_bus_i | input | 8 | Primary bus number |
| sec_bus_i | input | 8 | Secondary bus number |
| sub_bus_i | input | 8 | Subordinate bus number |
| abort_i | input | 1 | Target-side special cycle ended in master abort |
| dec_valid_o | output | 1 | Decision strobe |
| dec_o | output | 2 | Outcome: 0 other, 1 special, 2 forward, 3 ignore |
| cmd_o | output | 4 | Command for the target side |
| ad_o | output | 32 | Address word for the target side |
| launch_o | output | 1 | Start a special cycle on the target bus |
| resp_o | output | 2 | Initiator answer: 0 none, 1 retry, 2 complete |

## Verification
A bad bus-number compare or a bad field check shows up on dec_o and cmd_o in the very next cycle after the address phase, so the directed tests move one field at a time across its boundary. A tracker stuck in the wrong state is only visible at the next special-cycle attempt. It appears as a missing or extra launch_o, or as COMPLETE given too early or never. For this reason the tests repeat attempts before and after abort_i and mix in a non-matching attempt.

// File: rtl/t1cfg_pkg.sv
package t1cfg_pkg;
  localparam int unsigned CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [CMD_W-1:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;

  typedef enum logic [1:0] {
    DEC_OTHER   = 2'd0,
    DEC_SPECIAL = 2'd1,
    DEC_FORWARD = 2'd2,
    DEC_IGNORE  = 2'd3
  } dec_e;

  typedef enum logic [1:0] {
    RESP_NONE     = 2'd0,
    RESP_RETRY    = 2'd1,
    RESP_COMPLETE = 2'd2
  } resp_e;

  typedef enum logic [1:0] {
    TRK_IDLE    = 2'd0,
    TRK_PEND    = 2'd1,
    TRK_ABORTED = 2'd2
  } trk_e;
endpackage

// File: rtl/t1cfg_classify.sv
module t1cfg_classify
  import t1cfg_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 8
) (
  input  logic             valid_i,
  input  logic [AW-1:0]    ad_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             upstream_i,
  input  logic [BW-1:0]    pri_bus_i,
  input  logic [BW-1:0]    sec_bus_i,
  input  logic [BW-1:0]    sub_bus_i,
  output dec_e             dec_o,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int unsigned BUS_LSB = 16;
  localparam int unsigned DEV_LSB = 11;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned FN_LSB  = 8;
  localparam int unsigned FN_W    = 3;
  localparam int unsigned REG_LSB = 2;
  localparam int unsigned REG_W   = 6;

  logic [BW-1:0]    bus;
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic [REG_W-1:0] regn;
  logic             is_t1, is_rd, is_wr, is_sc;
  logic             sc_match, in_range, in_window;

  assign bus  = ad_i[BUS_LSB +: BW];
  assign dev  = ad_i[DEV_LSB +: DEV_W];
  assign fn   = ad_i[FN_LSB +: FN_W];
  assign regn = ad_i[REG_LSB +: REG_W];

  assign is_t1 = (ad_i[1:0] == 2'b01);
  assign is_rd = (cmd_i == CMD_CFG_RD);
  assign is_wr = (cmd_i == CMD_CFG_WR);
  assign is_sc = (cmd_i == CMD_SPECIAL);

  assign sc_match  = is_wr && (&dev) && (&fn) && (regn == '0) &&
                     (bus == (upstream_i ? pri_bus_i : sec_bus_i));
  assign in_range  = (bus > sec_bus_i) && (bus <= sub_bus_i);
  assign in_window = (bus >= sec_bus_i) && (bus <= sub_bus_i);

  always_comb begin
    dec_o = DEC_OTHER;
    if (is_t1) begin
      if (is_sc)                    dec_o = DEC_IGNORE;
      else if (upstream_i && is_rd) dec_o = DEC_IGNORE;
      else if (sc_match)            dec_o = DEC_SPECIAL;
      else if (!upstream_i && (is_rd || is_wr) && in_range) dec_o = DEC_FORWARD;
      else if (upstream_i && is_wr && !in_window)           dec_o = DEC_FORWARD;
    end
  end

  assign cmd_o = (dec_o == DEC_SPECIAL) ? CMD_SPECIAL : cmd_i;

  always_comb begin
    if (valid_i && is_t1 && upstream_i && is_rd)
      assert_up_read_ignored_R6: assert (dec_o == DEC_IGNORE);
    if (valid_i && !is_t1)
      assert_not_type1_other_R1: assert (dec_o == DEC_OTHER);
  end
endmodule

// File: rtl/t1cfg_sc_tracker.sv
module t1cfg_sc_tracker
  import t1cfg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] ad_i,
  input  logic          upstream_i,
  input  logic          abort_i,
  output logic          launch_o,
  output resp_e         resp_o
);
  trk_e          st_q;
  logic [AW-1:0] key_ad_q;
  logic          key_up_q;
  logic          hit;

  assign hit = (ad_i == key_ad_q) && (upstream_i == key_up_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= TRK_IDLE;
      key_ad_q <= '0;
      key_up_q <= 1'b0;
      launch_o <= 1'b0;
      resp_o   <= RESP_NONE;
    end else begin
      launch_o <= 1'b0;
      resp_o   <= RESP_NONE;
      if (st_q == TRK_PEND && abort_i) st_q <= TRK_ABORTED;
      if (req_i) begin
        unique case (st_q)
          TRK_IDLE: begin
            key_ad_q <= ad_i;
            key_up_q <= upstream_i;
            st_q     <= TRK_PEND;
            launch_o <= 1'b1;
            resp_o   <= RESP_RETRY;
          end
          TRK_ABORTED: begin
            if (hit) begin
              resp_o <= RESP_COMPLETE;
              st_q   <= TRK_IDLE;
            end else begin
              resp_o <= RESP_RETRY;
            end
          end
          default: resp_o <= RESP_RETRY;
        endcase
      end
    end
  end

  assert_launch_only_from_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (st_q == TRK_PEND) && $past(req_i));
  assert_complete_after_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o == RESP_COMPLETE) |-> (st_q == TRK_IDLE) && $past(st_q == TRK_ABORTED));
  assert_resp_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o != RESP_NONE) |-> $past(req_i));
endmodule

// File: rtl/t1cfg_fwd_decoder.sv
module t1cfg_fwd_decoder
  import t1cfg_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] ad_i,
  input  logic [3:0]    cmd_i,
  input  logic          upstream_i,
  input  logic          split_mode_i,
  input  logic [BW-1:0] pri_bus_i,
  input  logic [BW-1:0] sec_bus_i,
  input  logic [BW-1:0] sub_bus_i,
  input  logic          abort_i,
  output logic          dec_valid_o,
  output logic [1:0]    dec_o,
  output logic [3:0]    cmd_o,
  output logic [AW-1:0] ad_o,
  output logic          launch_o,
  output logic [1:0]    resp_o
);
  dec_e             cls;
  logic [CMD_W-1:0] cls_cmd;
  resp_e            trk_resp;
  logic             trk_req;

  t1cfg_classify #(.AW(AW), .BW(BW)) i_classify (
    .valid_i    (valid_i),
    .ad_i       (ad_i),
    .cmd_i      (cmd_i),
    .upstream_i (upstream_i),
    .pri_bus_i  (pri_bus_i),
    .sec_bus_i  (sec_bus_i),
    .sub_bus_i  (sub_bus_i),
    .dec_o      (cls),
    .cmd_o      (cls_cmd)
  );

  assign trk_req = valid_i && (cls == DEC_SPECIAL) && !split_mode_i;

  t1cfg_sc_tracker #(.AW(AW)) i_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (trk_req),
    .ad_i       (ad_i),
    .upstream_i (upstream_i),
    .abort_i    (abort_i),
    .launch_o   (launch_o),
    .resp_o     (trk_resp)
  );
  assign resp_o = trk_resp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_o       <= DEC_OTHER;
      cmd_o       <= '0;
      ad_o        <= '0;
    end else begin
      dec_valid_o <= valid_i;
      if (valid_i) begin
        dec_o <= cls;
        cmd_o <= cls_cmd;
        ad_o  <= ad_i;
      end
    end
  end

  assert_strobe_follows_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(valid_i));
  assert_special_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_o == DEC_SPECIAL) |-> (cmd_o == CMD_SPECIAL));
  assert_split_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(split_mode_i) |-> !launch_o && (resp_o == RESP_NONE));
endmodule

// File: tb/test_t1cfg_fwd_decoder.sv
module test_t1cfg_fwd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cmd = '0;
  logic        up = 1'b0;
  logic        split = 1'b1;
  logic [7:0]  pri = 8'h02, sec = 8'h05, sub = 8'h09;
  logic        abort = 1'b0;
  logic        dec_valid, launch;
  logic [1:0]  dec, resp;
  logic [3:0]  cmd_out;
  logic [31:0] ad_out;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  t1cfg_fwd_decoder i_t1cfg_fwd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ad_i(ad), .cmd_i(cmd),
    .upstream_i(up), .split_mode_i(split), .pri_bus_i(pri), .sec_bus_i(sec),
    .sub_bus_i(sub), .abort_i(abort), .dec_valid_o(dec_valid), .dec_o(dec),
    .cmd_o(cmd_out), .ad_o(ad_out), .launch_o(launch), .resp_o(resp)
  );

  function automatic logic [31:0] mk(input logic [7:0] bus, input logic [4:0] dv,
                                     input logic [2:0] fn, input logic [5:0] rg,
                                     input logic [1:0] t);
    return {8'h00, bus, dv, fn, rg, t};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one address phase, check outputs one cycle later
  task automatic phase(input string tag, input logic [31:0] a, input logic [3:0] c,
                       input logic u, input logic [1:0] exp_dec, input logic [3:0] exp_cmd);
    @(negedge clk);
    valid = 1'b1; ad = a; cmd = c; up = u;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " dec"}, {30'd0, dec}, {30'd0, exp_dec});
    chk({tag, " cmd"}, {28'd0, cmd_out}, {28'd0, exp_cmd});
  endtask

  task automatic t_reset;
    chk("reset dec_valid R8", {31'd0, dec_valid}, 32'd0);
    chk("reset launch R9", {31'd0, launch}, 32'd0);
    chk("reset resp R10", {30'd0, resp}, 32'd0);
  endtask

  task automatic t_classify;
    phase("R1 type0 bits", mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b00), 4'hB, 1'b0, 2'd0, 4'hB);
    phase("R1 mem cmd", mk(8'h06, 5'h00, 3'h0, 6'h0, 2'b01), 4'h6, 1'b0, 2'd0, 4'h6);
    phase("R2 R4 special down", mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01), 4'hB, 1'b0, 2'd1, 4'h1);
    chk("R4 ad passthrough", ad_out, mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01));
    chk("R11 no launch split", {31'd0, launch}, 32'd0);
    chk("R11 resp none split", {30'd0, resp}, 32'd0);
    phase("R2 dev mismatch", mk(8'h05, 5'h1e, 3'h7, 6'h0, 2'b01), 4'hB, 1'b0, 2'd0, 4'hB);
    phase("R2 fn mismatch", mk(8'h05, 5'h1f, 3'h6, 6'h0, 2'b01), 4'hB, 1'b0, 2'd0, 4'hB);
    phase("R2 reg mismatch", mk(8'h05, 5'h1f, 3'h7, 6'h1, 2'b01), 4'hB, 1'b0, 2'd0, 4'hB);
    phase("R2 read not special", mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01), 4'hA, 1'b0, 2'd0, 4'hA);
    phase("R3 special up pri", mk(8'h02, 5'h1f, 3'h7, 6'h0, 2'b01), 4'hB, 1'b1, 2'd1, 4'h1);
    phase("R3 down uses sec", mk(8'h02, 5'h1f, 3'h7, 6'h0, 2'b01), 4'hB, 1'b0, 2'd0, 4'hB);
    phase("R3 up bus sec", mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01), 4'hB, 1'b1, 2'd0, 4'hB);
    phase("R5 fwd sub edge", mk(8'h09, 5'h03, 3'h0, 6'h4, 2'b01), 4'hA, 1'b0, 2'd2, 4'hA);
    phase("R5 fwd low edge", mk(8'h06, 5'h03, 3'h0, 6'h4, 2'b01), 4'hB, 1'b0, 2'd2, 4'hB);
    phase("R5 above sub", mk(8'h0a, 5'h03, 3'h0, 6'h4, 2'b01), 4'hA, 1'b0, 2'd0, 4'hA);
    phase("R5 sc fields in range", mk(8'h07, 5'h1f, 3'h7, 6'h0, 2'b01), 4'hB, 1'b0, 2'd2, 4'hB);
    phase("R6 up read ignore", mk(8'h20, 5'h00, 3'h0, 6'h0, 2'b01), 4'hA, 1'b1, 2'd3, 4'hA);
    phase("R6 up write fwd", mk(8'h20, 5'h00, 3'h0, 6'h0, 2'b01), 4'hB, 1'b1, 2'd2, 4'hB);
    phase("R7 special rx", mk(8'h07, 5'h1f, 3'h7, 6'h0, 2'b01), 4'h1, 1'b0, 2'd3, 4'h1);
  endtask

  task automatic t_strobe;
    phase("R8 strobe", mk(8'h06, 5'h0, 3'h0, 6'h0, 2'b01), 4'hA, 1'b0, 2'd2, 4'hA);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'd0, dec_valid}, 32'd0);
  endtask

  task automatic t_tracker;
    logic [31:0] a_sc = mk(8'h05, 5'h1f, 3'h7, 6'h0, 2'b01);
    logic [31:0] b_sc = mk(8'h02, 5'h1f, 3'h7, 6'h0, 2'b01);
    split = 1'b0;
    phase("R9 first", a_sc, 4'hB, 1'b0, 2'd1, 4'h1);
    chk("R9 launch", {31'd0, launch}, 32'd1);
    chk("R9 retry", {30'd0, resp}, 32'd1);
    phase("R10 repeat", a_sc, 4'hB, 1'b0, 2'd1, 4'h1);
    chk("R10 no relaunch", {31'd0, launch}, 32'd0);
    chk("R10 retry pending", {30'd0, resp}, 32'd1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    phase("R10 other", b_sc, 4'hB, 1'b1, 2'd1, 4'h1);
    chk("R10 other retry", {30'd0, resp}, 32'd1);
    chk("R10 other no launch", {31'd0, launch}, 32'd0);
    phase("R10 match", a_sc, 4'hB, 1'b0, 2'd1, 4'h1);
    chk("R10 complete", {30'd0, resp}, 32'd2);
    phase("R10 freed", b_sc, 4'hB, 1'b1, 2'd1, 4'h1);
    chk("R10 new launch", {31'd0, launch}, 32'd1);
    chk("R10 new retry", {30'd0, resp}, 32'd1);
  endtask

  initial begin
    fork
      begin
        #20; t_reset();
        rst_n = 1'b1;
        t_classify();
        t_strobe();
        t_tracker();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule